// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns the address and cycle type of the current bus cycle into active-low select strobes. Software loads the decode windows and cycle attributes through a small register write port. The address is captured when a cycle starts and held until it ends. Every select is decoded combinationally from that captured address, so the strobes stay steady for the whole cycle.

There are three memory regions. The upper region ends at the top of the address space. The lower region starts at address zero. The middle region sits at a programmable base and is split into four equal quarters, one select each. A bank of seven peripheral selects decodes consecutive 256-byte pages above one shared base page, in memory space or in I/O space. One of these seven has no pin but still decodes.

For each cycle the block tells a downstream wait controller whether external ready is needed and how many wait states to insert. It also flags overlapping selects whose attributes disagree, and reports whether the address must be withheld from the multiplexed bus. The two highest peripheral selects can instead carry the latched word address bits.

Top module: `cs_decoder`

## Requirements
- R1: After reset only the upper region is enabled: it covers the top 1 KB, with 3 wait states and external ready required. No other select asserts until its register is written. The peripheral selects need the base register (index 4) and their group register (index 5 for selects 0 to 3, index 6 for selects 4 to 6), written in any order.
- R2: A start pulse latches bus_page, bus_wsel and bus_io, and begins a cycle. While the cycle lasts, input changes have no effect on the outputs. An end pulse without a start ends the cycle, and from the next cycle on no select asserts and attr_valid is 0.
- R3: Registers 0 (upper) and 1 (lower) share one layout: bits [1:0] wait count, bit 2 ready-required, bit 3 address-disable, bits [6:4] size code k. The region size is 1 KB << k. The upper select asserts when the address is at least 2^20 minus the size. The lower select asserts when the address is below the size. Both assert only in memory cycles (bus_io = 0).
- R4: Register 2 holds the middle base in 1 KB units. Register 3 holds bits [1:0] wait count, bit 2 ready-required and bits [6:4] size code k, and writing it enables the region. The region spans 4 KB << k, starting at the base with its low bits cleared to that alignment. mcs_n[j] asserts for quarter j, counted upward from the region start, in memory cycles only.
- R5: Register 4 bits [11:0] give the peripheral base page and bit 12 the space (1 = I/O). Select i asserts when the address bits [19:8] equal (base + i) modulo 4096 and bus_io equals the space bit.
- R6: Peripheral select 4 never drives pcs_n[4] low. Its hit still takes part in attribute selection and mismatch detection.
- R7: When register 6 bit 3 is set, pcs_n[5] carries latched address bit 1 and pcs_n[6] carries latched address bit 2. The decode of selects 5 and 6 then contributes no attributes.
- R8: The wait count for register 5 (selects 0 to 3) is its bits [2:0] mapped 0,1,2,3,4,5,6,7 to 0,1,2,3,5,7,9,15, and its bit 3 is ready-required. Register 6 (selects 4 to 6) uses bits [1:0] as a direct count and bit 2 as ready-required.
- R9: attr_valid is 1 when any select hits. attr_rdy and attr_wait come from the first hitting select in the order upper, lower, middle 0 to 3, peripheral 0 to 6.
- R10: attr_mismatch is 1 exactly when some hitting select has a ready flag or wait count that differs from the chosen attributes.
- R11: addr_disable is 1 when the upper select hits with its disable bit set, or the lower select hits with its disable bit set, whatever other selects also hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register index 0 to 6 |
| cfg_wdata | input | 13 | Register write data |
| bus_start | input | 1 | Latch the address and begin a cycle |
| bus_end | input | 1 | End the current cycle |
| bus_io | input | 1 | Cycle type: 1 = I/O, 0 = memory |
| bus_page | input | 12 | Address bits 19:8 |
| bus_wsel | input | 2 | Address bits 2:1 |
| ucs_n | output | 1 | Upper region select, active low |
| lcs_n | output | 1 | Lower region select, active low |
| mcs_n | output | 4 | Middle quarter selects, active low |
| pcs_n | output | 7 | Peripheral selects, or latched address bits on 6:5 |
| attr_valid | output | 1 | Some select hits |
| attr_rdy | output | 1 | External ready required |
| attr_wait | output | 4 | Wait states to insert |
| attr_mismatch | output | 1 | Overlapping selects disagree |
| addr_disable | output | 1 | Withhold the address from the bus |

## Verification
On every cycle the assertions check these properties. The captured address stays put during a cycle, and no strobe survives an end pulse. Memory strobes stay quiet in I/O cycles, and at most one middle quarter is active. A hit from the pinless select produces valid attributes. The repurposed peripheral selects never hit. A mismatch is only reported when two or more selects hit. Only the bench's sweeps can show the window arithmetic: region sizes and alignment, page wrap-around, the wait-count mapping, the priority order, and the enable sequencing after reset. The sweeps compare every output against a model computed from the register values.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef struct packed {
    logic       rdy;
    logic [3:0] wcnt;
  } cs_attr_t;

  localparam logic [2:0] REG_UPPER    = 3'd0;
  localparam logic [2:0] REG_LOWER    = 3'd1;
  localparam logic [2:0] REG_MID_BASE = 3'd2;
  localparam logic [2:0] REG_MID_CTL  = 3'd3;
  localparam logic [2:0] REG_PER_BASE = 3'd4;
  localparam logic [2:0] REG_PER_LO   = 3'd5;
  localparam logic [2:0] REG_PER_HI   = 3'd6;

  // extended wait encoding of the low peripheral group
  function automatic logic [3:0] per_wait_map(input logic [2:0] code);
    logic [3:0] r;
    case (code)
      3'd4:    r = 4'd5;
      3'd5:    r = 4'd7;
      3'd6:    r = 4'd9;
      3'd7:    r = 4'd15;
      default: r = {1'b0, code};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cs_cfg_regs.sv
module cs_cfg_regs
  import cs_pkg::*;
#(
  parameter int PAGE_W    = 12,
  parameter int BLK_W     = 10,
  parameter int N_PER     = 7,
  parameter int PER_SPLIT = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [2:0]            sel,
  input  logic [PAGE_W:0]       wdata,
  output cs_attr_t              up_attr,
  output logic                  up_da,
  output logic [2:0]            up_k,
  output cs_attr_t              lo_attr,
  output logic                  lo_da,
  output logic [2:0]            lo_k,
  output logic                  lo_arm,
  output logic [BLK_W-1:0]      mid_base,
  output logic [2:0]            mid_k,
  output cs_attr_t              mid_attr,
  output logic                  mid_arm,
  output logic [PAGE_W-1:0]     per_base,
  output logic                  per_io,
  output cs_attr_t [N_PER-1:0]  per_attr,
  output logic [N_PER-1:0]      per_arm,
  output logic                  amode
);

  logic [1:0] up_w, lo_w, mid_w, phi_w;
  logic       up_r, lo_r, mid_r, plo_r, phi_r;
  logic [2:0] plo_code;
  logic       pb_arm, plo_arm, phi_arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_w     <= 2'd3;
      up_r     <= 1'b1;
      up_da    <= 1'b0;
      up_k     <= 3'd0;
      lo_w     <= '0;
      lo_r     <= 1'b0;
      lo_da    <= 1'b0;
      lo_k     <= '0;
      lo_arm   <= 1'b0;
      mid_base <= '0;
      mid_w    <= '0;
      mid_r    <= 1'b0;
      mid_k    <= '0;
      mid_arm  <= 1'b0;
      per_base <= '0;
      per_io   <= 1'b0;
      pb_arm   <= 1'b0;
      plo_code <= '0;
      plo_r    <= 1'b0;
      plo_arm  <= 1'b0;
      phi_w    <= '0;
      phi_r    <= 1'b0;
      amode    <= 1'b0;
      phi_arm  <= 1'b0;
    end else if (we) begin
      case (sel)
        REG_UPPER: begin
          up_w  <= wdata[1:0];
          up_r  <= wdata[2];
          up_da <= wdata[3];
          up_k  <= wdata[6:4];
        end
        REG_LOWER: begin
          lo_w   <= wdata[1:0];
          lo_r   <= wdata[2];
          lo_da  <= wdata[3];
          lo_k   <= wdata[6:4];
          lo_arm <= 1'b1;
        end
        REG_MID_BASE: mid_base <= wdata[BLK_W-1:0];
        REG_MID_CTL: begin
          mid_w   <= wdata[1:0];
          mid_r   <= wdata[2];
          mid_k   <= wdata[6:4];
          mid_arm <= 1'b1;
        end
        REG_PER_BASE: begin
          per_base <= wdata[PAGE_W-1:0];
          per_io   <= wdata[PAGE_W];
          pb_arm   <= 1'b1;
        end
        REG_PER_LO: begin
          plo_code <= wdata[2:0];
          plo_r    <= wdata[3];
          plo_arm  <= 1'b1;
        end
        REG_PER_HI: begin
          phi_w   <= wdata[1:0];
          phi_r   <= wdata[2];
          amode   <= wdata[3];
          phi_arm <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign up_attr  = '{rdy: up_r,  wcnt: {2'b00, up_w}};
  assign lo_attr  = '{rdy: lo_r,  wcnt: {2'b00, lo_w}};
  assign mid_attr = '{rdy: mid_r, wcnt: {2'b00, mid_w}};

  for (genvar i = 0; i < N_PER; i++) begin : g_pattr
    if (i < PER_SPLIT) begin : g_lo
      assign per_attr[i] = '{rdy: plo_r, wcnt: per_wait_map(plo_code)};
      assign per_arm[i]  = pb_arm & plo_arm;
    end else begin : g_hi
      assign per_attr[i] = '{rdy: phi_r, wcnt: {2'b00, phi_w}};
      assign per_arm[i]  = pb_arm & phi_arm;
    end
  end

endmodule

// File: rtl/cs_mem_decode.sv
module cs_mem_decode #(
  parameter int BLK_W = 10,
  parameter int N_MID = 4
) (
  input  logic              cyc,
  input  logic              io,
  input  logic [BLK_W-1:0]  blk,
  input  logic [2:0]        up_k,
  input  logic [2:0]        lo_k,
  input  logic              lo_arm,
  input  logic [BLK_W-1:0]  mid_base,
  input  logic [2:0]        mid_k,
  input  logic              mid_arm,
  output logic              ucs_hit,
  output logic              lcs_hit,
  output logic [N_MID-1:0]  mcs_hit
);

  localparam int BW1   = BLK_W + 1;
  localparam int IDX_W = (N_MID > 1) ? $clog2(N_MID) : 1;

  logic             mem_cyc;
  logic [BW1-1:0]   blk_x, up_lim, lo_lim;
  logic [BLK_W-1:0] m_span, m_mask, m_start, m_off;
  logic [IDX_W-1:0] m_idx;
  logic             m_in;

  assign mem_cyc = cyc & ~io;
  assign blk_x   = {1'b0, blk};

  // upper region ends at the top of the space, lower starts at zero
  assign up_lim  = (BW1'(1) << BLK_W) - (BW1'(1) << up_k);
  assign lo_lim  = BW1'(1) << lo_k;
  assign ucs_hit = mem_cyc & (blk_x >= up_lim);
  assign lcs_hit = mem_cyc & lo_arm & (blk_x < lo_lim);

  // middle region aligned to its own span, split into N_MID equal parts
  assign m_span  = BLK_W'(N_MID) << mid_k;
  assign m_mask  = ~(m_span - BLK_W'(1));
  assign m_start = mid_base & m_mask;
  assign m_in    = mem_cyc & mid_arm & ((blk & m_mask) == m_start);
  assign m_off   = blk - m_start;
  assign m_idx   = IDX_W'(m_off >> mid_k);

  for (genvar j = 0; j < N_MID; j++) begin : g_mcs
    assign mcs_hit[j] = m_in & (m_idx == IDX_W'(j));
  end

endmodule

// File: rtl/cs_per_decode.sv
module cs_per_decode #(
  parameter int PAGE_W = 12,
  parameter int N_PER  = 7
) (
  input  logic              cyc,
  input  logic              io,
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] per_base,
  input  logic              per_io,
  input  logic [N_PER-1:0]  per_arm,
  input  logic              amode,
  output logic [N_PER-1:0]  per_hit
);

  logic space_ok;
  assign space_ok = cyc & (io == per_io);

  for (genvar i = 0; i < N_PER; i++) begin : g_pcs
    logic [PAGE_W-1:0] win;
    logic              taken;
    assign win   = per_base + PAGE_W'(i);
    // the two top selects lose their decode when they carry address bits
    assign taken = (i >= N_PER - 2) ? amode : 1'b0;
    assign per_hit[i] = space_ok & per_arm[i] & ~taken & (page == win);
  end

endmodule

// File: rtl/cs_attr_merge.sv
module cs_attr_merge
  import cs_pkg::*;
#(
  parameter int N_SRC = 13
) (
  input  logic [N_SRC-1:0]     hit,
  input  cs_attr_t [N_SRC-1:0] attr,
  output logic                 valid,
  output cs_attr_t             pick,
  output logic                 mismatch
);

  always_comb begin
    pick = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hit[i]) pick = attr[i];
    end
  end

  always_comb begin
    mismatch = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (hit[i] && (attr[i] != pick)) mismatch = 1'b1;
    end
  end

  assign valid = |hit;

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 8,
  parameter int BLK_SHIFT  = 10,
  parameter int N_MID      = 4,
  parameter int N_PER      = 7,
  parameter int PER_SPLIT  = 4,
  parameter int PER_HIDDEN = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [2:0]                   cfg_sel,
  input  logic [ADDR_W-PAGE_SHIFT:0]   cfg_wdata,
  input  logic                         bus_start,
  input  logic                         bus_end,
  input  logic                         bus_io,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] bus_page,
  input  logic [1:0]                   bus_wsel,
  output logic                         ucs_n,
  output logic                         lcs_n,
  output logic [N_MID-1:0]             mcs_n,
  output logic [N_PER-1:0]             pcs_n,
  output logic                         attr_valid,
  output logic                         attr_rdy,
  output logic [3:0]                   attr_wait,
  output logic                         attr_mismatch,
  output logic                         addr_disable
);

  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int BLK_W  = ADDR_W - BLK_SHIFT;
  localparam int PG2BLK = BLK_SHIFT - PAGE_SHIFT;
  localparam int N_SRC  = 2 + N_MID + N_PER;

  // latched cycle state
  logic              cyc_q, io_q;
  logic [PAGE_W-1:0] page_q;
  logic [1:0]        wsel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= 1'b0;
      io_q   <= 1'b0;
      page_q <= '0;
      wsel_q <= '0;
    end else if (bus_start) begin
      cyc_q  <= 1'b1;
      io_q   <= bus_io;
      page_q <= bus_page;
      wsel_q <= bus_wsel;
    end else if (bus_end) begin
      cyc_q  <= 1'b0;
    end
  end

  cs_attr_t              up_attr, lo_attr, mid_attr;
  cs_attr_t [N_PER-1:0]  per_attr;
  logic                  up_da, lo_da, lo_arm, mid_arm, per_io, amode;
  logic [2:0]            up_k, lo_k, mid_k;
  logic [BLK_W-1:0]      mid_base;
  logic [PAGE_W-1:0]     per_base;
  logic [N_PER-1:0]      per_arm;

  cs_cfg_regs #(
    .PAGE_W(PAGE_W), .BLK_W(BLK_W), .N_PER(N_PER), .PER_SPLIT(PER_SPLIT)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .up_attr(up_attr), .up_da(up_da), .up_k(up_k),
    .lo_attr(lo_attr), .lo_da(lo_da), .lo_k(lo_k), .lo_arm(lo_arm),
    .mid_base(mid_base), .mid_k(mid_k), .mid_attr(mid_attr), .mid_arm(mid_arm),
    .per_base(per_base), .per_io(per_io), .per_attr(per_attr),
    .per_arm(per_arm), .amode(amode)
  );

  logic             ucs_hit, lcs_hit;
  logic [N_MID-1:0] mcs_hit;
  logic [N_PER-1:0] per_hit;

  cs_mem_decode #(.BLK_W(BLK_W), .N_MID(N_MID)) u_mem (
    .cyc(cyc_q), .io(io_q), .blk(page_q[PAGE_W-1:PG2BLK]),
    .up_k(up_k), .lo_k(lo_k), .lo_arm(lo_arm),
    .mid_base(mid_base), .mid_k(mid_k), .mid_arm(mid_arm),
    .ucs_hit(ucs_hit), .lcs_hit(lcs_hit), .mcs_hit(mcs_hit)
  );

  cs_per_decode #(.PAGE_W(PAGE_W), .N_PER(N_PER)) u_per (
    .cyc(cyc_q), .io(io_q), .page(page_q), .per_base(per_base),
    .per_io(per_io), .per_arm(per_arm), .amode(amode), .per_hit(per_hit)
  );

  // priority order: upper, lower, middle quarters, peripheral selects
  logic [N_SRC-1:0]     src_hit;
  cs_attr_t [N_SRC-1:0] src_attr;

  assign src_hit = {per_hit, mcs_hit, lcs_hit, ucs_hit};
  assign src_attr[0] = up_attr;
  assign src_attr[1] = lo_attr;
  for (genvar j = 0; j < N_MID; j++) begin : g_mattr
    assign src_attr[2+j] = mid_attr;
  end
  for (genvar i = 0; i < N_PER; i++) begin : g_pattr
    assign src_attr[2+N_MID+i] = per_attr[i];
  end

  cs_attr_t pick;

  cs_attr_merge #(.N_SRC(N_SRC)) u_merge (
    .hit(src_hit), .attr(src_attr), .valid(attr_valid),
    .pick(pick), .mismatch(attr_mismatch)
  );

  assign attr_rdy     = pick.rdy;
  assign attr_wait    = pick.wcnt;
  assign addr_disable = (ucs_hit & up_da) | (lcs_hit & lo_da);

  assign ucs_n = ~ucs_hit;
  assign lcs_n = ~lcs_hit;
  assign mcs_n = ~mcs_hit;

  for (genvar i = 0; i < N_PER; i++) begin : g_pin
    if (i == PER_HIDDEN) begin : g_nopin
      assign pcs_n[i] = 1'b1;
    end else if (i == N_PER - 1) begin : g_a2
      assign pcs_n[i] = amode ? wsel_q[1] : ~per_hit[i];
    end else if (i == N_PER - 2) begin : g_a1
      assign pcs_n[i] = amode ? wsel_q[0] : ~per_hit[i];
    end else begin : g_plain
      assign pcs_n[i] = ~per_hit[i];
    end
  end

  // R2: latched cycle state is held while a cycle runs
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc_q && !bus_start) |=> ($stable(page_q) && $stable(io_q) && $stable(wsel_q)));

  // R2: an end pulse clears every strobe on the next cycle
  p_end_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_end && !bus_start) |=> (ucs_n && lcs_n && (&mcs_n) && !attr_valid));

  // R3: memory strobes stay quiet in I/O cycles
  p_memtype_r3: assert property (@(posedge clk) disable iff (rst)
    io_q |-> (ucs_n && lcs_n && (&mcs_n)));

  // R4: at most one middle quarter at a time
  p_mcs_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mcs_n));

  // R6: the pinless select still yields attributes
  p_hidden_attr_r6: assert property (@(posedge clk) disable iff (rst)
    per_hit[PER_HIDDEN] |-> attr_valid);

  // R7: repurposed selects never hit
  p_amode_r7: assert property (@(posedge clk) disable iff (rst)
    amode |-> (!per_hit[N_PER-1] && !per_hit[N_PER-2]));

  // R10: a mismatch needs two or more hitting selects
  p_mismatch_r10: assert property (@(posedge clk) disable iff (rst)
    attr_mismatch |-> ($countones(src_hit) >= 2));

endmodule

// File: tb/cs_decoder_test.sv
`timescale 1ns/1ps
module cs_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [12:0] cfg_wdata = '0;
  logic        bus_start = 1'b0, bus_end = 1'b0, bus_io = 1'b0;
  logic [11:0] bus_page = '0;
  logic [1:0]  bus_wsel = '0;
  logic        ucs_n, lcs_n, attr_valid, attr_rdy, attr_mismatch, addr_disable;
  logic [3:0]  mcs_n, attr_wait;
  logic [6:0]  pcs_n;

  always #10 clk = ~clk;

  cs_decoder uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .bus_start(bus_start), .bus_end(bus_end), .bus_io(bus_io),
    .bus_page(bus_page), .bus_wsel(bus_wsel),
    .ucs_n(ucs_n), .lcs_n(lcs_n), .mcs_n(mcs_n), .pcs_n(pcs_n),
    .attr_valid(attr_valid), .attr_rdy(attr_rdy), .attr_wait(attr_wait),
    .attr_mismatch(attr_mismatch), .addr_disable(addr_disable)
  );

  int n_tests = 0, n_fail = 0;

  // mirror of the programmed configuration
  int u_k = 0, u_wait = 3, u_rdy = 1, u_da = 0;
  int l_k = 0, l_wait = 0, l_rdy = 0, l_da = 0, l_arm = 0;
  int m_base = 0, m_k = 0, m_wait = 0, m_rdy = 0, m_arm = 0;
  int p_base = 0, p_io = 0, pb_arm = 0;
  int plo_code = 0, plo_rdy = 0, plo_arm = 0;
  int phi_wait = 0, phi_rdy = 0, p_am = 0, phi_arm = 0;

  function automatic int wmap(int c);
    case (c)
      4: return 5;
      5: return 7;
      6: return 9;
      7: return 15;
      default: return c;
    endcase
  endfunction

  function automatic logic [20:0] expect_out(int a, bit io);
    int pg = a >> 8;
    int blk = a >> 10;
    int wb = (a >> 1) & 3;
    bit h[14];
    int rw[14];
    bit rr[14];
    logic [3:0] mcs;
    logic [6:0] pcs;
    int span, mb, first;
    bit valid, mism, da;
    h[0] = !io && (blk >= 1024 - (1 << u_k)); rr[0] = u_rdy[0]; rw[0] = u_wait;
    h[1] = (l_arm != 0) && !io && (blk < (1 << l_k)); rr[1] = l_rdy[0]; rw[1] = l_wait;
    span = 4 << m_k;
    mb = m_base - (m_base % span);
    for (int j = 0; j < 4; j++) begin
      h[2+j] = (m_arm != 0) && !io && blk >= mb && blk < mb + span && (((blk - mb) >> m_k) == j);
      rr[2+j] = m_rdy[0]; rw[2+j] = m_wait;
      mcs[j] = !h[2+j];
    end
    for (int i = 0; i < 7; i++) begin
      bit armed;
      armed = (pb_arm != 0) && ((i < 4) ? (plo_arm != 0) : (phi_arm != 0));
      h[6+i] = armed && (int'(io) == p_io) && (pg == ((p_base + i) % 4096)) && !((p_am != 0) && i >= 5);
      rr[6+i] = (i < 4) ? plo_rdy[0] : phi_rdy[0];
      rw[6+i] = (i < 4) ? wmap(plo_code) : phi_wait;
      pcs[i] = !h[6+i];
    end
    pcs[4] = 1'b1;
    if (p_am != 0) begin
      pcs[5] = wb[0];
      pcs[6] = wb[1];
    end
    first = -1;
    for (int k = 13; k >= 0; k--) if (h[k]) first = k;
    valid = (first >= 0);
    mism = 1'b0;
    if (valid)
      for (int k = 0; k < 14; k++)
        if (h[k] && (rr[k] != rr[first] || rw[k] != rw[first])) mism = 1'b1;
    da = (h[0] && u_da != 0) || (h[1] && l_da != 0);
    return {!h[0], !h[1], mcs, pcs, valid,
            valid ? rr[first] : 1'b0, valid ? 4'(rw[first]) : 4'd0, mism, da};
  endfunction

  function automatic logic [20:0] got_out();
    return {ucs_n, lcs_n, mcs_n, pcs_n, attr_valid, attr_rdy, attr_wait, attr_mismatch, addr_disable};
  endfunction

  task automatic check(input logic [20:0] got, input logic [20:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cfg(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 13'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_upper(input int k, input int w, input int r, input int d);
    u_k = k; u_wait = w; u_rdy = r; u_da = d;
    cfg(0, w | (r << 2) | (d << 3) | (k << 4));
  endtask
  task automatic set_lower(input int k, input int w, input int r, input int d);
    l_k = k; l_wait = w; l_rdy = r; l_da = d; l_arm = 1;
    cfg(1, w | (r << 2) | (d << 3) | (k << 4));
  endtask
  task automatic set_mid(input int base, input int k, input int w, input int r);
    m_base = base; m_k = k; m_wait = w; m_rdy = r;
    cfg(2, base);
    cfg(3, w | (r << 2) | (k << 4));
    m_arm = 1;
  endtask
  task automatic set_pbase(input int base, input int io);
    p_base = base; p_io = io; pb_arm = 1;
    cfg(4, base | (io << 12));
  endtask
  task automatic set_plo(input int code, input int r);
    plo_code = code; plo_rdy = r; plo_arm = 1;
    cfg(5, code | (r << 3));
  endtask
  task automatic set_phi(input int w, input int r, input int am);
    phi_wait = w; phi_rdy = r; p_am = am; phi_arm = 1;
    cfg(6, w | (r << 2) | (am << 3));
  endtask

  // start a cycle, let it latch, sample one cycle later
  task automatic run(input int a, input bit io, input string tag);
    @(negedge clk);
    bus_start = 1'b1; bus_io = io; bus_page = 12'(a >> 8); bus_wsel = 2'((a >> 1) & 3);
    @(negedge clk);
    bus_start = 1'b0;
    check(got_out(), expect_out(a, io), tag);
  endtask

  task automatic sweep(input bit io, input string tag);
    for (int b = 0; b < 4096; b++) run(b * 256 + ((b * 37) & 255), io, tag);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check(got_out(), {1'b1, 1'b1, 4'hF, 7'h7F, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, "R1 idle");

    // R1 R5: only the group register written, no base: peripherals stay off
    set_plo(1, 0);
    sweep(1'b0, "R1 R5 reset defaults");

    set_upper(3, 2, 0, 1);
    set_lower(2, 1, 0, 1);
    set_mid(64, 1, 0, 1);
    set_pbase(12'h100, 0);
    set_plo(5, 1);
    set_phi(2, 0, 0);
    sweep(1'b0, "R3 R4 R5 R6 R8 R9 R10 R11 memory");
    sweep(1'b1, "R3 R5 io");

    set_pbase(12'hFFC, 1);
    set_phi(3, 1, 1);
    sweep(1'b1, "R5 R6 R7 R8 io wrap");

    set_lower(2, 1, 0, 0);
    set_pbase(0, 0);
    set_plo(1, 0);
    set_phi(1, 0, 0);
    sweep(1'b0, "R9 R10 matched overlap");

    // R2: hold and end behaviour
    set_upper(0, 3, 1, 0);
    run(20'hFFC00, 1'b0, "R2 start");
    @(negedge clk);
    bus_page = 12'h000; bus_io = 1'b1;
    repeat (3) @(negedge clk);
    check(got_out(), expect_out(20'hFFC00, 1'b0), "R2 held");
    bus_end = 1'b1;
    @(negedge clk);
    bus_end = 1'b0;
    check(got_out(), {1'b1, 1'b1, 4'hF, 7'h7F, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, "R2 ended");
    bus_page = 12'hFFF; bus_io = 1'b0;
    repeat (2) @(negedge clk);
    check(got_out(), {1'b1, 1'b1, 4'hF, 7'h7F, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0}, "R2 no start");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule